// File: doc/BRIEF.md
# Video Raster Timing Generator with Early Fetch Strobe

This block produces the raster for a video-mode display link. It runs a pixel counter and a line counter, decodes horizontal and vertical sync pulses and a data-enable window, and outputs both counters. Timing is supplied as active size, sync start, sync end and total for each axis. The porches follow from these: front porch is sync start minus active, sync width is sync end minus sync start, and back porch is total minus sync end. Within a line the order is active region, front porch, sync, then back porch. Frames follow the same order line by line.

Before the active lines of the next frame, an upstream pixel fetcher may need more lead time than the lines after the sync pulse provide. The block takes a worst-case fetch latency in lines and computes a prefetch line count, clamped to the vertical front porch. It then issues a single-cycle strobe at the matching point in the frame and reports the 1-based frame pixel position of that strobe.

The block also handles three interface cases. A command-link interface flag forces both syncs active-high. A split flag halves the horizontal figures so that one of two side-by-side interfaces can be driven. Malformed timing sets are refused. New settings are adopted only between frames. Fixed border and underflow fill colours are output as constants.

Top module: `vtg_timing_gen`

## Requirements
- R1: While running, `pix_x` counts 0 to horizontal total − 1, and then `line_y` advances. `line_y` wraps to 0 after vertical total − 1, together with `pix_x`.
- R2: `de` is 1 exactly when running with `pix_x` < active width and `line_y` < active height.
- R3: A sync pulse is asserted while the axis counter c satisfies sync_start ≤ c < sync_end. The output is active-high (1 during the pulse). When the axis negative-sync flag is set, the output is active-low, with an idle level of 1.
- R4: When `cfg_link_cmd` is 1, both sync outputs are active-high regardless of the negative-sync flags.
- R5: When `cfg_split` is 1, the horizontal active, sync start, sync end and total inputs are each shifted right by one bit before use.
- R6: With budget B = vertical total − vertical sync start (the back porch plus sync width), a worst-case latency L_w ≤ B gives 0 prefetch lines, `fetch_en` = 0, `fetch_start` = 0 and no strobe.
- R7: If L_w > B and the vertical front porch is less than L_w − B, the prefetch line count equals the front porch.
- R8: Otherwise the prefetch line count is exactly L_w − B.
- R9: With N prefetch lines (N ≠ 0), `fetch_start` = (vertical total − N) × horizontal total + 1. `fetch_strobe` pulses for one cycle per frame, at `line_y` = vertical total − N and `pix_x` = 0.
- R10: A set is invalid if, on either axis, sync end > total, sync start < active, sync end < sync start, or active = 0. While `enable` is 1, an invalid set raises `cfg_err` one cycle later. An invalid set is never adopted: a stopped raster stays stopped, and a running raster keeps its old settings.
- R11: While running, new settings take effect only at the frame wrap, so a frame in progress keeps its timing.
- R12: `border_color` is all zeros and `underflow_color` is all ones at all times.
- R13: When `enable` is 0, the raster stops on the next edge, with counters at 0, `de` = 0 and no strobe. When `enable` is 1 again, a valid set loads on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the raster |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_sync_start | input | HW | Pixel where hsync begins |
| cfg_h_sync_end | input | HW | Pixel where hsync ends |
| cfg_h_total | input | HW | Pixels per line |
| cfg_v_active | input | VW | Active lines per frame |
| cfg_v_sync_start | input | VW | Line where vsync begins |
| cfg_v_sync_end | input | VW | Line where vsync ends |
| cfg_v_total | input | VW | Lines per frame |
| cfg_hsync_neg | input | 1 | Active-low hsync |
| cfg_vsync_neg | input | 1 | Active-low vsync |
| cfg_link_cmd | input | 1 | Command-link interface: force active-high syncs |
| cfg_split | input | 1 | Halve horizontal timing |
| cfg_fetch_budget | input | VW | Worst-case fetch latency in lines |
| pix_x | output | HW | Pixel counter |
| line_y | output | VW | Line counter |
| de | output | 1 | Data enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| fetch_strobe | output | 1 | Next-frame fetch start pulse |
| fetch_en | output | 1 | Prefetch in use |
| fetch_lines | output | VW | Prefetch line count |
| fetch_start | output | HW+VW+1 | Frame pixel position of the strobe |
| cfg_err | output | 1 | Rejected timing set |
| border_color | output | CW | Border colour |
| underflow_color | output | CW | Underflow fill colour |

## Verification
The bench builds the block with 10-bit counters on both axes, 8-bit colours and split support present. The 10-bit counters keep the product width of `fetch_start` at 21 bits, while still leaving headroom above the small rasters used. Rasters are kept to at most 17 by 17, so every frame wraps within a few hundred cycles. This lets the random configurations, which include halved, negative-polarity, invalid and mid-frame changes, cross many frame boundaries. It also puts all three prefetch outcomes within reach using budgets of 0 to 12 lines.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   typedef enum logic [1:0] {
      PF_OFF     = 2'd0,
      PF_CLAMPED = 2'd1,
      PF_EXACT   = 2'd2
   } pf_mode_e;
endpackage

// File: rtl/vtg_cfg_calc.sv
module vtg_cfg_calc #(
   parameter int HW = 12,
   parameter int VW = 12,
   parameter bit SPLIT_SUPPORT = 1'b1,
   localparam int PW = HW + VW + 1
) (
   input  logic [HW-1:0] h_act_i,
   input  logic [HW-1:0] h_ss_i,
   input  logic [HW-1:0] h_se_i,
   input  logic [HW-1:0] h_tot_i,
   input  logic [VW-1:0] v_act_i,
   input  logic [VW-1:0] v_ss_i,
   input  logic [VW-1:0] v_se_i,
   input  logic [VW-1:0] v_tot_i,
   input  logic          split_i,
   input  logic          link_cmd_i,
   input  logic          hneg_i,
   input  logic          vneg_i,
   input  logic [VW-1:0] budget_i,
   output logic [HW-1:0] h_act_o,
   output logic [HW-1:0] h_ss_o,
   output logic [HW-1:0] h_se_o,
   output logic [HW-1:0] h_tot_o,
   output logic          valid_o,
   output logic          hneg_o,
   output logic          vneg_o,
   output logic [VW-1:0] lines_o,
   output logic [PW-1:0] start_o
);
   import vtg_pkg::*;

   if (HW < 2 || VW < 2) begin : g_bad_width
      $error("vtg_cfg_calc: counter widths must be at least 2");
   end

   if (SPLIT_SUPPORT) begin : g_split
      assign h_act_o = split_i ? (h_act_i >> 1) : h_act_i;
      assign h_ss_o  = split_i ? (h_ss_i  >> 1) : h_ss_i;
      assign h_se_o  = split_i ? (h_se_i  >> 1) : h_se_i;
      assign h_tot_o = split_i ? (h_tot_i >> 1) : h_tot_i;
   end else begin : g_nosplit
      assign h_act_o = h_act_i;
      assign h_ss_o  = h_ss_i;
      assign h_se_o  = h_se_i;
      assign h_tot_o = h_tot_i;
   end

   assign hneg_o = hneg_i & ~link_cmd_i;
   assign vneg_o = vneg_i & ~link_cmd_i;

   logic h_ok, v_ok;
   assign h_ok = (h_se_o <= h_tot_o) && (h_ss_o >= h_act_o) &&
                 (h_se_o >= h_ss_o) && (h_act_o != '0);
   assign v_ok = (v_se_i <= v_tot_i) && (v_ss_i >= v_act_i) &&
                 (v_se_i >= v_ss_i) && (v_act_i != '0);
   assign valid_o = h_ok && v_ok;

   logic [VW-1:0] front_porch, sof_lines, need_lines;
   pf_mode_e      mode;
   logic [PW-1:0] fetch_line_w, line_len_w;

   always_comb begin
      front_porch = v_ss_i - v_act_i;
      sof_lines   = v_tot_i - v_ss_i;
      need_lines  = budget_i - sof_lines;
      if (sof_lines >= budget_i)        mode = PF_OFF;
      else if (front_porch < need_lines) mode = PF_CLAMPED;
      else                               mode = PF_EXACT;
      case (mode)
         PF_CLAMPED: lines_o = front_porch;
         PF_EXACT:   lines_o = need_lines;
         default:    lines_o = '0;
      endcase
      fetch_line_w = PW'(v_tot_i - lines_o);
      line_len_w   = PW'(h_tot_o);
      start_o      = (lines_o != '0) ? (fetch_line_w * line_len_w + PW'(1)) : '0;
   end
endmodule

// File: rtl/vtg_axis_decode.sv
module vtg_axis_decode #(
   parameter int W = 12
) (
   input  logic [W-1:0] cnt_i,
   input  logic [W-1:0] act_i,
   input  logic [W-1:0] ss_i,
   input  logic [W-1:0] se_i,
   input  logic         neg_i,
   input  logic         run_i,
   output logic         active_o,
   output logic         sync_o
);
   logic in_pulse;
   assign in_pulse = run_i && (cnt_i >= ss_i) && (cnt_i < se_i);
   assign active_o = run_i && (cnt_i < act_i);
   assign sync_o   = in_pulse ^ neg_i;
endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen #(
   parameter int HW = 12,
   parameter int VW = 12,
   parameter int CW = 8,
   parameter bit SPLIT_SUPPORT = 1'b1,
   localparam int PW = HW + VW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [HW-1:0] cfg_h_active,
   input  logic [HW-1:0] cfg_h_sync_start,
   input  logic [HW-1:0] cfg_h_sync_end,
   input  logic [HW-1:0] cfg_h_total,
   input  logic [VW-1:0] cfg_v_active,
   input  logic [VW-1:0] cfg_v_sync_start,
   input  logic [VW-1:0] cfg_v_sync_end,
   input  logic [VW-1:0] cfg_v_total,
   input  logic          cfg_hsync_neg,
   input  logic          cfg_vsync_neg,
   input  logic          cfg_link_cmd,
   input  logic          cfg_split,
   input  logic [VW-1:0] cfg_fetch_budget,
   output logic [HW-1:0] pix_x,
   output logic [VW-1:0] line_y,
   output logic          de,
   output logic          hsync,
   output logic          vsync,
   output logic          fetch_strobe,
   output logic          fetch_en,
   output logic [VW-1:0] fetch_lines,
   output logic [PW-1:0] fetch_start,
   output logic          cfg_err,
   output logic [CW-1:0] border_color,
   output logic [CW-1:0] underflow_color
);
   if (CW < 1) begin : g_bad_cw
      $error("vtg_timing_gen: colour width must be positive");
   end

   logic [HW-1:0] n_hact, n_hss, n_hse, n_htot;
   logic          cfg_ok, n_hneg, n_vneg;
   logic [VW-1:0] n_lines;
   logic [PW-1:0] n_start;

   vtg_cfg_calc #(.HW(HW), .VW(VW), .SPLIT_SUPPORT(SPLIT_SUPPORT)) u_calc (
      .h_act_i(cfg_h_active), .h_ss_i(cfg_h_sync_start),
      .h_se_i(cfg_h_sync_end), .h_tot_i(cfg_h_total),
      .v_act_i(cfg_v_active), .v_ss_i(cfg_v_sync_start),
      .v_se_i(cfg_v_sync_end), .v_tot_i(cfg_v_total),
      .split_i(cfg_split), .link_cmd_i(cfg_link_cmd),
      .hneg_i(cfg_hsync_neg), .vneg_i(cfg_vsync_neg),
      .budget_i(cfg_fetch_budget),
      .h_act_o(n_hact), .h_ss_o(n_hss), .h_se_o(n_hse), .h_tot_o(n_htot),
      .valid_o(cfg_ok), .hneg_o(n_hneg), .vneg_o(n_vneg),
      .lines_o(n_lines), .start_o(n_start)
   );

   logic [HW-1:0] hact_q, hss_q, hse_q, htot_q, hcnt_q;
   logic [VW-1:0] vact_q, vss_q, vse_q, vtot_q, vcnt_q, pf_lines_q;
   logic [PW-1:0] pf_start_q;
   logic          hneg_q, vneg_q, run_q, err_q;
   logic          line_end, frame_end;

   assign line_end  = (hcnt_q == htot_q - HW'(1));
   assign frame_end = line_end && (vcnt_q == vtot_q - VW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hact_q <= '0; hss_q <= '0; hse_q <= '0; htot_q <= '0;
         vact_q <= '0; vss_q <= '0; vse_q <= '0; vtot_q <= '0;
         hneg_q <= 1'b0; vneg_q <= 1'b0;
         pf_lines_q <= '0; pf_start_q <= '0;
         hcnt_q <= '0; vcnt_q <= '0; run_q <= 1'b0; err_q <= 1'b0;
      end else begin
         err_q <= enable && !cfg_ok;
         if (!enable) begin
            run_q  <= 1'b0;
            hcnt_q <= '0;
            vcnt_q <= '0;
         end else if (!run_q || frame_end) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
            if (cfg_ok) begin
               run_q  <= 1'b1;
               hact_q <= n_hact; hss_q <= n_hss; hse_q <= n_hse; htot_q <= n_htot;
               vact_q <= cfg_v_active; vss_q <= cfg_v_sync_start;
               vse_q  <= cfg_v_sync_end; vtot_q <= cfg_v_total;
               hneg_q <= n_hneg; vneg_q <= n_vneg;
               pf_lines_q <= n_lines; pf_start_q <= n_start;
            end
         end else if (line_end) begin
            hcnt_q <= '0;
            vcnt_q <= vcnt_q + VW'(1);
         end else begin
            hcnt_q <= hcnt_q + HW'(1);
         end
      end
   end

   logic h_act_w, v_act_w;

   vtg_axis_decode #(.W(HW)) u_hdec (
      .cnt_i(hcnt_q), .act_i(hact_q), .ss_i(hss_q), .se_i(hse_q),
      .neg_i(hneg_q), .run_i(run_q), .active_o(h_act_w), .sync_o(hsync)
   );
   vtg_axis_decode #(.W(VW)) u_vdec (
      .cnt_i(vcnt_q), .act_i(vact_q), .ss_i(vss_q), .se_i(vse_q),
      .neg_i(vneg_q), .run_i(run_q), .active_o(v_act_w), .sync_o(vsync)
   );

   assign de              = h_act_w && v_act_w;
   assign pix_x           = hcnt_q;
   assign line_y          = vcnt_q;
   assign fetch_en        = (pf_lines_q != '0);
   assign fetch_lines     = pf_lines_q;
   assign fetch_start     = pf_start_q;
   assign fetch_strobe    = run_q && fetch_en && (hcnt_q == '0) &&
                            (vcnt_q == vtot_q - pf_lines_q);
   assign cfg_err         = err_q;
   assign border_color    = '0;
   assign underflow_color = '1;

   assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (hcnt_q < htot_q && vcnt_q < vtot_q));
   assert_de_outside_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hsync == hneg_q));
   assert_lines_in_porch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (pf_lines_q <= vtot_q - vact_q));
   assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_strobe |=> !fetch_strobe);
   assert_start_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(cfg_ok));
   assert_reload_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && (!$stable(htot_q) || !$stable(pf_start_q)))
      |-> (hcnt_q == '0 && vcnt_q == '0));
   assert_stop_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !run_q);
endmodule

// File: tb/vtg_timing_gen_tb.sv
module vtg_timing_gen_tb;
   localparam int HW = 10;
   localparam int VW = 10;
   localparam int CW = 8;
   localparam int PW = HW + VW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [HW-1:0] h_act, h_ss, h_se, h_tot;
   logic [VW-1:0] v_act, v_ss, v_se, v_tot, budget;
   logic hneg = 1'b0, vneg = 1'b0, lcmd = 1'b0, split = 1'b0;

   logic [HW-1:0] pix_x;
   logic [VW-1:0] line_y, fetch_lines;
   logic de, hsync, vsync, fetch_strobe, fetch_en, cfg_err;
   logic [PW-1:0] fetch_start;
   logic [CW-1:0] border_color, underflow_color;

   vtg_timing_gen #(.HW(HW), .VW(VW), .CW(CW), .SPLIT_SUPPORT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_h_active(h_act), .cfg_h_sync_start(h_ss), .cfg_h_sync_end(h_se),
      .cfg_h_total(h_tot), .cfg_v_active(v_act), .cfg_v_sync_start(v_ss),
      .cfg_v_sync_end(v_se), .cfg_v_total(v_tot), .cfg_hsync_neg(hneg),
      .cfg_vsync_neg(vneg), .cfg_link_cmd(lcmd), .cfg_split(split),
      .cfg_fetch_budget(budget), .pix_x(pix_x), .line_y(line_y), .de(de),
      .hsync(hsync), .vsync(vsync), .fetch_strobe(fetch_strobe),
      .fetch_en(fetch_en), .fetch_lines(fetch_lines), .fetch_start(fetch_start),
      .cfg_err(cfg_err), .border_color(border_color),
      .underflow_color(underflow_color)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit chk_on = 1'b0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [HW-1:0] halve(input logic [HW-1:0] x, input logic s);
      return s ? (x >> 1) : x;
   endfunction

   function automatic bit axis_ok(input int a, input int s, input int e, input int t);
      return (e <= t) && (s >= a) && (e >= s) && (a != 0);
   endfunction

   function automatic int want_lines(input int va, input int vs, input int vt, input int b);
      int sof, fp;
      sof = vt - vs;
      fp  = vs - va;
      if (sof >= b) return 0;
      if (fp < b - sof) return fp;
      return b - sof;
   endfunction

   function automatic longint want_start(input int vt, input int ht, input int n);
      if (n == 0) return 0;
      return longint'(vt - n) * ht + 1;
   endfunction

   // reference raster built from the requirements
   logic m_run, m_err, m_hn, m_vn;
   int m_h, m_v, m_ha, m_hs, m_he, m_ht, m_va, m_vs, m_ve, m_vt, m_n;
   longint m_st;

   always @(posedge clk or negedge rst_n) begin : model
      int a, s, e, t, n;
      bit ok;
      if (!rst_n) begin
         m_run <= 0; m_err <= 0; m_hn <= 0; m_vn <= 0; m_h <= 0; m_v <= 0;
         m_ha <= 0; m_hs <= 0; m_he <= 0; m_ht <= 0;
         m_va <= 0; m_vs <= 0; m_ve <= 0; m_vt <= 0; m_n <= 0; m_st <= 0;
      end else begin
         a = int'(halve(h_act, split)); s = int'(halve(h_ss, split));
         e = int'(halve(h_se, split));  t = int'(halve(h_tot, split));
         ok = axis_ok(a, s, e, t) && axis_ok(int'(v_act), int'(v_ss), int'(v_se), int'(v_tot));
         n = want_lines(int'(v_act), int'(v_ss), int'(v_tot), int'(budget));
         m_err <= enable && !ok;
         if (!enable) begin
            m_run <= 0; m_h <= 0; m_v <= 0;
         end else if (!m_run || (m_h == m_ht - 1 && m_v == m_vt - 1)) begin
            m_h <= 0; m_v <= 0;
            if (ok) begin
               m_run <= 1;
               m_ha <= a; m_hs <= s; m_he <= e; m_ht <= t;
               m_va <= int'(v_act); m_vs <= int'(v_ss); m_ve <= int'(v_se); m_vt <= int'(v_tot);
               m_hn <= hneg & ~lcmd; m_vn <= vneg & ~lcmd;
               m_n <= n; m_st <= want_start(int'(v_tot), t, n);
            end
         end else if (m_h == m_ht - 1) begin
            m_h <= 0; m_v <= m_v + 1;
         end else begin
            m_h <= m_h + 1;
         end
      end
   end

   always @(posedge clk) begin
      #3;
      if (chk_on) begin
         chk("R1", "pix_x", pix_x, m_h);
         chk("R1", "line_y", line_y, m_v);
         chk("R2", "de", de, m_run && m_h < m_ha && m_v < m_va);
         chk("R3", "hsync", hsync, (m_run && m_h >= m_hs && m_h < m_he) ^ m_hn);
         chk("R3", "vsync", vsync, (m_run && m_v >= m_vs && m_v < m_ve) ^ m_vn);
         chk("R9", "fetch_strobe", fetch_strobe,
             m_run && m_n != 0 && m_h == 0 && m_v == m_vt - m_n);
         chk("R9", "fetch_start", fetch_start, m_st);
         chk("R8", "fetch_lines", fetch_lines, m_n);
         chk("R10", "cfg_err", cfg_err, m_err);
         chk("R12", "colours", {border_color, underflow_color}, 16'h00FF);
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic wait_at(input int x, input int y);
      do step(); while (!(pix_x == x && line_y == y));
   endtask

   task automatic cfg_a();
      h_act = 4; h_ss = 5; h_se = 6; h_tot = 8;
      v_act = 4; v_ss = 6; v_se = 7; v_tot = 9;
   endtask

   task automatic count_strobes(input int cycles, output int cnt, output int line_at);
      cnt = 0; line_at = -1;
      for (int i = 0; i < cycles; i++) begin
         step();
         if (fetch_strobe) begin cnt++; line_at = int'(line_y); end
      end
   endtask

   initial begin
      #800000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt, at;
      cfg_a(); budget = 3;
      repeat (3) step();
      chk("R13", "reset pix_x", pix_x, 0);
      chk("R13", "reset de", de, 0);
      chk("R13", "reset hsync", hsync, 0);
      chk("R10", "reset err", cfg_err, 0);
      chk("R12", "border", border_color, 8'h00);
      chk("R12", "underflow", underflow_color, 8'hFF);
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R6: budget equal to the 3 lines after sync start
      enable = 1'b1;
      step();
      chk("R6", "fetch_en", fetch_en, 0);
      chk("R6", "fetch_start", fetch_start, 0);
      count_strobes(144, cnt, at);
      chk("R6", "strobe count", cnt, 0);

      // R1: line wrap
      wait_at(7, 0);
      step();
      chk("R1", "wrap pix", pix_x, 0);
      chk("R1", "wrap line", line_y, 1);

      // R2: data enable edges
      wait_at(3, 3);
      chk("R2", "de last active", de, 1);
      step();
      chk("R2", "de front porch", de, 0);

      // R11 and R8: change mid-frame, adopt at the wrap
      wait_at(2, 1);
      budget = 4;
      step();
      chk("R11", "lines held", fetch_lines, 0);
      wait_at(0, 0);
      chk("R8", "exact lines", fetch_lines, 1);
      chk("R9", "start exact", fetch_start, 65);
      count_strobes(72, cnt, at);
      chk("R9", "strobe count", cnt, 1);
      chk("R9", "strobe line", at, 8);

      // R7: clamp to front porch of 2 lines
      budget = 8;
      wait_at(0, 0);
      chk("R7", "clamped lines", fetch_lines, 2);
      chk("R7", "start clamped", fetch_start, 57);

      // R5: doubled horizontal figures halved
      enable = 1'b0; step();
      chk("R13", "stopped pix", pix_x, 0);
      chk("R13", "stopped strobe", fetch_strobe, 0);
      split = 1'b1; h_act = 8; h_ss = 10; h_se = 12; h_tot = 16; budget = 4;
      enable = 1'b1; step();
      chk("R5", "split start", fetch_start, 65);
      wait_at(7, 0); step();
      chk("R5", "split wrap", pix_x, 0);

      // R3 and R4 polarity
      enable = 1'b0; step();
      split = 1'b0; cfg_a(); hneg = 1'b1; vneg = 1'b1;
      enable = 1'b1; step();
      chk("R3", "hsync idle low-active", hsync, 1);
      chk("R3", "vsync idle low-active", vsync, 1);
      wait_at(5, 0);
      chk("R3", "hsync pulse low-active", hsync, 0);
      enable = 1'b0; step();
      lcmd = 1'b1; enable = 1'b1; step();
      chk("R4", "hsync forced idle", hsync, 0);
      chk("R4", "vsync forced idle", vsync, 0);
      wait_at(5, 0);
      chk("R4", "hsync forced pulse", hsync, 1);
      lcmd = 1'b0; hneg = 1'b0; vneg = 1'b0;

      // R10: invalid set while running is flagged and refused
      wait_at(1, 2);
      h_se = 9; budget = 8;
      step();
      chk("R10", "err raised", cfg_err, 1);
      wait_at(0, 0);
      chk("R10", "old start kept", fetch_start, 65);
      wait_at(7, 0); step();
      chk("R10", "old total kept", pix_x, 0);
      // invalid while stopped: stays stopped
      enable = 1'b0; step();
      v_se = 10; h_se = 6; enable = 1'b1;
      repeat (5) step();
      chk("R10", "no start", pix_x, 0);
      chk("R10", "err stopped", cfg_err, 1);
      cfg_a();
      step(); step();
      chk("R13", "restart", pix_x, 1);

      // random configurations
      void'($urandom(32'd20240611));
      for (int k = 0; k < 40; k++) begin
         int a, f, w, b, va, vf, vw, vb;
         a = 1 + $urandom % 8; f = $urandom % 4; w = $urandom % 4; b = $urandom % 4;
         va = 1 + $urandom % 8; vf = $urandom % 4; vw = $urandom % 4; vb = $urandom % 4;
         h_act = HW'(a); h_ss = HW'(a + f); h_se = HW'(a + f + w); h_tot = HW'(a + f + w + b);
         v_act = VW'(va); v_ss = VW'(va + vf); v_se = VW'(va + vf + vw); v_tot = VW'(va + vf + vw + vb);
         if ($urandom % 8 == 0) h_se = h_tot + 1;
         if ($urandom % 8 == 0) v_ss = v_act - 1;
         budget = VW'($urandom % 13);
         hneg = $urandom % 2; vneg = $urandom % 2; lcmd = ($urandom % 4 == 0);
         split = ($urandom % 4 == 0);
         if ($urandom % 6 == 0) begin
            enable = 1'b0;
            repeat (1 + $urandom % 4) step();
            enable = 1'b1;
         end
         repeat (20 + $urandom % 300) step();
      end

      chk_on = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule